// File: doc/BRIEF.md
# Voltage-Code Word Slave on a Two-Wire Management Bus

This block is a target on an SMBus-style two-wire bus. It holds two 5-bit voltage codes and one converter-enable request bit. A host updates the codes with a Write Word transaction and reads them back with a Read Word transaction. The Read Word uses a repeated start after the command byte.

The bus pins are sampled on the system clock: two synchronizer flops, then an edge detector. SDA is driven only through an active-low pull enable, which models an open-drain pad. Only the top three bits of the command byte select an operation. Every write command has its data bytes acknowledged. Changes are applied only when a complete frame closes with a stop condition, so a frame that is cut short leaves all state untouched.

Downstream logic uses the two codes and the enable bit directly. Each code also has a one-clock pulse that marks the cycle in which it was rewritten.

Top module: `smb_vid_slave`

## Requirements
- R1: After reset both codes are 5'b11111, the enable bit is 0, both update pulses are 0 and SDA is released (`sda_pull_n_o` = 1).
- R2: An address byte whose upper seven bits are 7'b1110001 and whose LSB is 0 is acknowledged by pulling SDA low during the ninth SCL high phase. Any other address gets no acknowledge, and the rest of that frame is ignored until the next start.
- R3: A command byte whose bits [7:5] are 3'b001 (setup) loads bits [7:3] of the first data byte into code 0 and bits [7:3] of the second data byte into code 1. Both loads happen when the stop condition is seen.
- R4: Command bits [7:5] = 3'b000 set the enable bit, and 3'b011 clear it, when the stop condition is seen. For both commands the two data bytes are acknowledged and the codes are unchanged. Command bits [4:0] are don't-care.
- R5: Command bits [7:5] of 3'b1xx are reserved. The command byte and both data bytes are acknowledged, and no code, enable bit or pulse changes.
- R6: After command bits [7:5] = 3'b010 (read-back), a repeated start and the address with LSB 1, the slave sends code 0 and then code 1. Each byte is {code[4:0], 2'b00, enable}, MSB first, and changes only while SCL is low.
- R7: When the host does not acknowledge the first read byte, the slave releases SDA for the remainder of the frame.
- R8: An address with LSB 1 that does not directly follow an acknowledged read-back command, through a repeated start, is not acknowledged.
- R9: A start condition in the middle of a frame, or a stop before the second data byte, commits nothing from that frame. A complete frame that follows still takes effect.
- R10: Each code update raises its pulse for exactly one clock, in the cycle the new code first appears. Setup raises both pulses together. Enable-bit changes raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_pull_n_o | output | 1 | 0 pulls SDA low, 1 releases it |
| vid0_o | output | 5 | Voltage code 0 |
| vid1_o | output | 5 | Voltage code 1 |
| run_o | output | 1 | Converter-enable request bit |
| vid0_upd_o | output | 1 | One-clock pulse when code 0 is rewritten |
| vid1_upd_o | output | 1 | One-clock pulse when code 1 is rewritten |

## Verification
A wrong frame state shows up at the first ninth-clock slot that follows it. The acknowledge is then missing or appears where none is due, and the bench sees this within one SCL period. A wrong staged code or command kind shows up on the code or enable outputs four system clocks after the stop condition. The bench compares those outputs against its model on every clock, so the mismatch is caught on that exact cycle. A bad read shift register corrupts a specific bit of the returned byte, and the bench reads that bit in the middle of its SCL high phase.

// File: rtl/smb_vid_pkg.sv
`timescale 1ns/1ps
package smb_vid_pkg;

    localparam int VID_W  = 5;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        CK_ON,
        CK_OFF,
        CK_SETUP,
        CK_READ,
        CK_NONE
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WLO,
        ST_WHI,
        ST_WEND,
        ST_RWAIT,
        ST_RLO,
        ST_RHI,
        ST_HOLD
    } frame_st_e;

    // Only the three top command bits select an operation.
    function automatic cmd_kind_e decode_cmd(input logic [2:0] top);
        cmd_kind_e k;
        case (top)
            3'b000:  k = CK_ON;
            3'b011:  k = CK_OFF;
            3'b001:  k = CK_SETUP;
            3'b010:  k = CK_READ;
            default: k = CK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/smb_pin_sync.sv
`timescale 1ns/1ps
module smb_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    typedef struct packed {
        logic [LINES-1:0][STAGES-1:0] pipe;
        logic [LINES-1:0]             prev;
    } sync_t;

    sync_t sq_q, sq_d;
    logic [LINES-1:0] raw;
    logic [LINES-1:0] now;

    assign raw[L_SCL] = scl_i;
    assign raw[L_SDA] = sda_i;

    always_comb begin
        sq_d = sq_q;
        for (int k = 0; k < LINES; k++) begin
            sq_d.pipe[k] = {sq_q.pipe[k][STAGES-2:0], raw[k]};
            sq_d.prev[k] = sq_q.pipe[k][STAGES-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sq_q <= '1;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        for (int k = 0; k < LINES; k++) begin
            now[k] = sq_q.pipe[k][STAGES-1];
        end
    end

    assign scl_o   = now[L_SCL];
    assign sda_o   = now[L_SDA];
    assign rise_o  = now[L_SCL] & ~sq_q.prev[L_SCL];
    assign fall_o  = ~now[L_SCL] & sq_q.prev[L_SCL];
    assign start_o = now[L_SCL] & sq_q.prev[L_SCL] & sq_q.prev[L_SDA] & ~now[L_SDA];
    assign stop_o  = now[L_SCL] & sq_q.prev[L_SCL] & ~sq_q.prev[L_SDA] & now[L_SDA];

endmodule

// File: rtl/smb_frame_fsm.sv
`timescale 1ns/1ps
module smb_frame_fsm
    import smb_vid_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'b1110001
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             sda_i,
    input  logic [VID_W-1:0] vid0_i,
    input  logic [VID_W-1:0] vid1_i,
    input  logic             run_i,
    output logic             pull_n_o,
    output logic             commit_o,
    output cmd_kind_e        kind_o,
    output logic [VID_W-1:0] lo_o,
    output logic [VID_W-1:0] hi_o
);
    localparam int          PAD_W    = BYTE_W - VID_W - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        frame_st_e          st;
        frame_st_e          after_ack;
        logic [CNT_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0]  rx_sh;
        logic [BYTE_W-1:0]  tx_sh;
        logic               pull_n;
        logic               ack_pend;
        logic               rd_ok;
        logic               mack;
        cmd_kind_e          kind;
        logic [VID_W-1:0]   lo;
        logic [VID_W-1:0]   hi;
        logic               commit;
    } frame_t;

    frame_t fq_q, fq_d;
    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] rd_byte0;
    logic [BYTE_W-1:0] rd_byte1;
    logic              reading;
    logic              active;

    assign byte_in  = {fq_q.rx_sh[BYTE_W-2:0], sda_i};
    assign rd_byte0 = {vid0_i, {PAD_W{1'b0}}, run_i};
    assign rd_byte1 = {vid1_i, {PAD_W{1'b0}}, run_i};
    assign reading  = (fq_q.st == ST_RLO) || (fq_q.st == ST_RHI);
    assign active   = (fq_q.st == ST_ADDR) || (fq_q.st == ST_CMD) ||
                      (fq_q.st == ST_WLO)  || (fq_q.st == ST_WHI) || reading;

    always_comb begin
        fq_d        = fq_q;
        fq_d.commit = 1'b0;
        if (start_i) begin
            fq_d.st       = ST_ADDR;
            fq_d.bit_cnt  = '0;
            fq_d.pull_n   = 1'b1;
            fq_d.ack_pend = 1'b0;
            fq_d.rd_ok    = (fq_q.st == ST_RWAIT);
        end else if (stop_i) begin
            fq_d.st       = ST_IDLE;
            fq_d.pull_n   = 1'b1;
            fq_d.ack_pend = 1'b0;
            fq_d.rd_ok    = 1'b0;
            fq_d.commit   = (fq_q.st == ST_WEND);
        end else if (active) begin
            if (rise_i) begin
                if (fq_q.bit_cnt < ACK_BIT) begin
                    fq_d.bit_cnt = fq_q.bit_cnt + 1'b1;
                    fq_d.rx_sh   = byte_in;
                    if (fq_q.bit_cnt == LAST_BIT && !reading) begin
                        case (fq_q.st)
                            ST_ADDR: begin
                                fq_d.rd_ok = 1'b0;
                                if (byte_in[BYTE_W-1:1] == SLAVE_ADDR &&
                                    (!byte_in[0] || fq_q.rd_ok)) begin
                                    fq_d.ack_pend  = 1'b1;
                                    fq_d.after_ack = byte_in[0] ? ST_RLO : ST_CMD;
                                end else begin
                                    fq_d.st       = ST_IDLE;
                                    fq_d.ack_pend = 1'b0;
                                end
                            end
                            ST_CMD: begin
                                fq_d.kind      = decode_cmd(byte_in[BYTE_W-1 -: 3]);
                                fq_d.ack_pend  = 1'b1;
                                fq_d.after_ack = (decode_cmd(byte_in[BYTE_W-1 -: 3]) == CK_READ)
                                                 ? ST_RWAIT : ST_WLO;
                            end
                            ST_WLO: begin
                                fq_d.lo        = byte_in[BYTE_W-1 -: VID_W];
                                fq_d.ack_pend  = 1'b1;
                                fq_d.after_ack = ST_WHI;
                            end
                            ST_WHI: begin
                                fq_d.hi        = byte_in[BYTE_W-1 -: VID_W];
                                fq_d.ack_pend  = 1'b1;
                                fq_d.after_ack = ST_WEND;
                            end
                            default: begin
                                fq_d.ack_pend = 1'b0;
                            end
                        endcase
                    end
                end else if (fq_q.bit_cnt == ACK_BIT) begin
                    fq_d.bit_cnt = ACK_DONE;
                    fq_d.mack    = ~sda_i;
                end
            end else if (fall_i) begin
                if (fq_q.bit_cnt == ACK_DONE) begin
                    fq_d.pull_n   = 1'b1;
                    fq_d.bit_cnt  = '0;
                    fq_d.ack_pend = 1'b0;
                    if (reading) begin
                        if (fq_q.st == ST_RLO && fq_q.mack) begin
                            fq_d.st     = ST_RHI;
                            fq_d.tx_sh  = rd_byte1;
                            fq_d.pull_n = rd_byte1[BYTE_W-1];
                        end else begin
                            fq_d.st = ST_HOLD;
                        end
                    end else begin
                        fq_d.st = fq_q.after_ack;
                        if (fq_q.after_ack == ST_RLO) begin
                            fq_d.tx_sh  = rd_byte0;
                            fq_d.pull_n = rd_byte0[BYTE_W-1];
                        end
                    end
                end else if (fq_q.bit_cnt == ACK_BIT) begin
                    fq_d.pull_n = reading ? 1'b1 : ~fq_q.ack_pend;
                end else if (reading && fq_q.bit_cnt != '0) begin
                    fq_d.tx_sh  = fq_q.tx_sh << 1;
                    fq_d.pull_n = fq_q.tx_sh[BYTE_W-2];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fq_q           <= '0;
            fq_q.st        <= ST_IDLE;
            fq_q.after_ack <= ST_IDLE;
            fq_q.kind      <= CK_NONE;
            fq_q.pull_n    <= 1'b1;
        end else begin
            fq_q <= fq_d;
        end
    end

    assign pull_n_o = fq_q.pull_n;
    assign commit_o = fq_q.commit;
    assign kind_o   = fq_q.kind;
    assign lo_o     = fq_q.lo;
    assign hi_o     = fq_q.hi;

endmodule

// File: rtl/smb_vid_regs.sv
`timescale 1ns/1ps
module smb_vid_regs
    import smb_vid_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       commit_i,
    input  cmd_kind_e                  kind_i,
    input  logic [NREG-1:0][VID_W-1:0] load_i,
    output logic [NREG-1:0][VID_W-1:0] vid_o,
    output logic [NREG-1:0]            upd_o,
    output logic                       run_o
);
    typedef struct packed {
        logic [NREG-1:0][VID_W-1:0] vid;
        logic [NREG-1:0]            upd;
        logic                       run;
    } regs_t;

    regs_t rq_q, rq_d;

    always_comb begin
        rq_d     = rq_q;
        rq_d.upd = '0;
        if (commit_i) begin
            case (kind_i)
                CK_SETUP: begin
                    for (int i = 0; i < NREG; i++) begin
                        rq_d.vid[i] = load_i[i];
                        rq_d.upd[i] = 1'b1;
                    end
                end
                CK_ON:   rq_d.run = 1'b1;
                CK_OFF:  rq_d.run = 1'b0;
                default: rq_d.run = rq_q.run;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rq_q     <= '0;
            rq_q.vid <= '1;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign vid_o = rq_q.vid;
    assign upd_o = rq_q.upd;
    assign run_o = rq_q.run;

endmodule

// File: rtl/smb_vid_slave.sv
`timescale 1ns/1ps
module smb_vid_slave
    import smb_vid_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'b1110001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_n_o,
    output logic [VID_W-1:0] vid0_o,
    output logic [VID_W-1:0] vid1_o,
    output logic             run_o,
    output logic             vid0_upd_o,
    output logic             vid1_upd_o
);
    localparam int NREG = 2;

    logic scl_sync;
    logic sda_sync;
    logic start_det;
    logic stop_det;
    logic scl_rise;
    logic scl_fall;
    logic commit;
    cmd_kind_e kind;
    logic [VID_W-1:0] stage_lo;
    logic [VID_W-1:0] stage_hi;
    logic [NREG-1:0][VID_W-1:0] load_vec;
    logic [NREG-1:0][VID_W-1:0] vid_vec;
    logic [NREG-1:0]            upd_vec;

    smb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_o   (scl_sync),
        .sda_o   (sda_sync),
        .start_o (start_det),
        .stop_o  (stop_det),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    smb_frame_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_frame (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_det),
        .stop_i   (stop_det),
        .rise_i   (scl_rise),
        .fall_i   (scl_fall),
        .sda_i    (sda_sync),
        .vid0_i   (vid_vec[0]),
        .vid1_i   (vid_vec[1]),
        .run_i    (run_o),
        .pull_n_o (sda_pull_n_o),
        .commit_o (commit),
        .kind_o   (kind),
        .lo_o     (stage_lo),
        .hi_o     (stage_hi)
    );

    assign load_vec[0] = stage_lo;
    assign load_vec[1] = stage_hi;

    smb_vid_regs #(.NREG(NREG)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .commit_i (commit),
        .kind_i   (kind),
        .load_i   (load_vec),
        .vid_o    (vid_vec),
        .upd_o    (upd_vec),
        .run_o    (run_o)
    );

    assign vid0_o     = vid_vec[0];
    assign vid1_o     = vid_vec[1];
    assign vid0_upd_o = upd_vec[0];
    assign vid1_upd_o = upd_vec[1];

endmodule

// File: rtl/smb_vid_slave_chk.sv
`timescale 1ns/1ps
module smb_vid_slave_chk
    import smb_vid_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             scl_sync,
    input logic             start_det,
    input logic             commit,
    input logic             sda_pull_n_o,
    input logic [VID_W-1:0] vid0_o,
    input logic [VID_W-1:0] vid1_o,
    input logic             run_o,
    input logic             vid0_upd_o,
    input logic             vid1_upd_o
);

    a_r2_release_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_det |=> sda_pull_n_o)
        else $error("R2: SDA still pulled after a start condition");

    a_r6_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sda_pull_n_o) |-> !$past(scl_sync))
        else $error("R6: SDA drive changed while SCL was high");

    a_r3_vid0_needs_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(vid0_o) |-> vid0_upd_o)
        else $error("R3: code 0 changed without its pulse");

    a_r3_vid1_needs_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(vid1_o) |-> vid1_upd_o)
        else $error("R3: code 1 changed without its pulse");

    a_r4_run_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(run_o) |-> $past(commit))
        else $error("R4: enable bit changed outside a committed frame");

    a_r10_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vid0_upd_o |=> !vid0_upd_o)
        else $error("R10: update pulse longer than one clock");

    a_r10_pulses_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vid0_upd_o == vid1_upd_o)
        else $error("R10: update pulses not raised together");

endmodule

bind smb_vid_slave smb_vid_slave_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_sync     (scl_sync),
    .start_det    (start_det),
    .commit       (commit),
    .sda_pull_n_o (sda_pull_n_o),
    .vid0_o       (vid0_o),
    .vid1_o       (vid1_o),
    .run_o        (run_o),
    .vid0_upd_o   (vid0_upd_o),
    .vid1_upd_o   (vid1_upd_o)
);

// File: tb/smb_vid_slave_bench.sv
`timescale 1ns/1ps
module smb_vid_slave_bench;

    localparam logic [6:0] ADDR = 7'b1110001;
    localparam int HALF = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_n;
    logic sda_line;
    logic [4:0] vid0, vid1;
    logic run, upd0, upd1;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & sda_pull_n;

    smb_vid_slave u_smb_vid_slave (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_pull_n_o (sda_pull_n),
        .vid0_o       (vid0),
        .vid1_o       (vid1),
        .run_o        (run),
        .vid0_upd_o   (upd0),
        .vid1_upd_o   (upd1)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    logic [4:0] e_r0 = 5'h1f, e_r1 = 5'h1f;
    logic       e_run = 1'b0;
    logic       e_pulse = 1'b0;
    logic       p_valid = 1'b0, p_pulse = 1'b0, p_run = 1'b0;
    logic [4:0] p_r0 = '0, p_r1 = '0;
    logic       pend_armed = 1'b0;
    int         pend_at = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            cyc++;
            e_pulse = 1'b0;
            if (pend_armed && cyc == pend_at) begin
                e_r0 = p_r0; e_r1 = p_r1; e_run = p_run; e_pulse = p_pulse;
                pend_armed = 1'b0;
            end
            check(cur_req, "vid0", vid0, e_r0);
            check(cur_req, "vid1", vid1, e_r1);
            check(cur_req, "run", run, e_run);
            check({cur_req, "/R10"}, "upd0", upd0, e_pulse);
            check({cur_req, "/R10"}, "upd1", upd1, e_pulse);
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; w(4);
        sda_m = 1'b1; w(12);
        scl_m = 1'b1; w(HALF);
        sda_m = 1'b0; w(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        w(4); sda_m = 1'b0; w(12);
        scl_m = 1'b1; w(HALF);
        sda_m = 1'b1;
        if (p_valid) begin
            pend_at = cyc + 5;
            pend_armed = 1'b1;
            p_valid = 1'b0;
        end
        w(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            w(4); sda_m = b[i]; w(12);
            scl_m = 1'b1; w(HALF);
            scl_m = 1'b0;
        end
        w(4); sda_m = 1'b1; w(12);
        scl_m = 1'b1; w(HALF/2);
        check(req, "ack", (sda_line == 1'b0), exp_ack);
        w(HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, input logic [7:0] exp, input string req);
        logic [7:0] got;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            w(4); sda_m = 1'b1; w(12);
            scl_m = 1'b1; w(HALF/2);
            got[i] = sda_line;
            w(HALF/2);
            scl_m = 1'b0;
        end
        w(4); sda_m = ~mack; w(12);
        scl_m = 1'b1; w(HALF);
        scl_m = 1'b0;
        check(req, "read byte", got, exp);
    endtask

    // Full Write Word with the bench's own expectation of its effect.
    task automatic write_word(input logic [6:0] a, input logic [7:0] cmd,
                              input logic [7:0] lo, input logic [7:0] hi, input string req);
        logic hit;
        hit = (a == ADDR);
        cur_req = req;
        bus_start();
        send_byte({a, 1'b0}, hit, req);
        send_byte(cmd, hit, req);
        send_byte(lo, hit, req);
        send_byte(hi, hit, req);
        p_r0 = e_r0; p_r1 = e_r1; p_run = e_run; p_pulse = 1'b0;
        if (hit) begin
            case (cmd[7:5])
                3'b001: begin p_r0 = lo[7:3]; p_r1 = hi[7:3]; p_pulse = 1'b1; end
                3'b000: p_run = 1'b1;
                3'b011: p_run = 1'b0;
                default: ;
            endcase
            p_valid = (cmd[7:5] == 3'b001) || (cmd[7:5] == 3'b000) || (cmd[7:5] == 3'b011);
        end
        bus_stop();
        w(8);
    endtask

    task automatic read_back(input logic ack_first, input string req);
        cur_req = req;
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, req);
        send_byte(8'h5c, 1'b1, req);
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b1, req);
        recv_byte(ack_first, {e_r0, 2'b00, e_run}, req);
        if (ack_first) recv_byte(1'b0, {e_r1, 2'b00, e_run}, req);
        else           recv_byte(1'b0, 8'hff, "R7");
        bus_stop();
        w(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        w(5);
        rst_n = 1'b1;
        w(4);
        check("R1", "sda released", sda_pull_n, 1);
        check("R1", "vid0 reset", vid0, 5'h1f);
        check("R1", "vid1 reset", vid1, 5'h1f);
        check("R1", "run reset", run, 0);

        // R3: setup, only bits [7:3] of each data byte matter
        write_word(ADDR, 8'h2b, 8'ha8, 8'h33, "R3");
        // R6: read back both codes in order
        read_back(1'b1, "R6");
        // R4: on, low command bits don't-care
        write_word(ADDR, 8'h1f, 8'h00, 8'hff, "R4");
        read_back(1'b1, "R6");
        // R4: off
        write_word(ADDR, 8'h7a, 8'h55, 8'haa, "R4");
        // R5: reserved codes
        write_word(ADDR, 8'h80, 8'h00, 8'h00, "R5");
        write_word(ADDR, 8'he0, 8'hf8, 8'hf8, "R5");
        // R2: foreign address, frame ignored
        write_word(7'b1110010, 8'h20, 8'h00, 8'h00, "R2");
        write_word(7'b0110001, 8'h00, 8'h00, 8'h00, "R2");

        // R9: start after data low aborts, following frame commits
        cur_req = "R9";
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R9");
        send_byte(8'h20, 1'b1, "R9");
        send_byte(8'h00, 1'b1, "R9");
        w(4);
        write_word(ADDR, 8'h20, 8'hf8, 8'h08, "R9");
        // R9: stop before data high commits nothing
        cur_req = "R9";
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R9");
        send_byte(8'h20, 1'b1, "R9");
        send_byte(8'h00, 1'b1, "R9");
        bus_stop();
        w(8);

        // R8: read address with no read-back command before it
        cur_req = "R8";
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b0, "R8");
        bus_stop();
        w(8);
        // R8: read-back command, then a fresh start (after stop) is not a repeated start
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R8");
        send_byte(8'h40, 1'b1, "R8");
        bus_stop();
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b0, "R8");
        bus_stop();
        w(8);

        // R7: host NACKs first byte
        write_word(ADDR, 8'h00, 8'h00, 8'h00, "R4");
        read_back(1'b0, "R7");
        // R3/R10: code extremes
        write_word(ADDR, 8'h3f, 8'h07, 8'hff, "R3");
        read_back(1'b1, "R6");
        w(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule